// File: doc/BRIEF.md
# Serial EEPROM Read Target (two-wire bus)

This block is a two-wire (I2C) bus target that behaves like a 512-byte serial EEPROM seen from the read side. It holds a 512x8 storage array, loaded through a simple synchronous preload port. It answers three read flows. A current-address read starts from a start condition and a read-mode header, and returns bytes from an internal address counter. A random-address read first sets the counter: a write-mode header, then an upper and a lower address byte, then a repeated start and a read-mode header. A sequential read keeps sending bytes for as long as the controller acknowledges each one.

The bus pins follow an open-drain model. The block samples the wired SDA level on `sda_in` and pulls the line low while `sda_oe` is 1. SCL comes in on `scl_in`; the target never holds SCL low. Both lines pass through a synchronizer before start, stop and clock edges are decoded. Any data bytes that follow the address in a write-mode transfer are acknowledged and thrown away, so a write transfer only moves the address counter.

Top module: `serial_rom_target`

## Requirements
- R1: A header byte whose upper seven bits equal the target address (parameter, default 0x50) is acknowledged: the target pulls SDA low (`sda_oe`=1) during the ninth clock. Header bit 0 chooses the direction: 0 for write, 1 for read.
- R2: A header with any other address gets no acknowledge. SDA stays released (`sda_oe`=0) through the rest of that transfer, until the next start condition.
- R3: In write mode the target acknowledges the upper and the lower address byte. After a repeated start and a read-mode header, the first data byte comes from the address {upper[0], lower[7:0]}.
- R4: Data bytes are sent most significant bit first. `sda_oe` changes only while SCL is low, except that a start or stop condition releases it at once.
- R5: When the controller pulls SDA low on the ninth clock of a data byte (ACK), the next byte, from the next address, is driven right after that clock.
- R6: The byte after address 0x1FF comes from address 0x000, and the stream goes on with no break.
- R7: When the controller leaves SDA high on the ninth clock (NACK), the target releases SDA and drives no more bits until a new start condition. A stop condition returns the target to idle.
- R8: The address counter advances by one on the ninth clock of every byte sent and keeps its value across stop conditions. A later current-address read therefore starts at the address after the last byte sent.
- R9: Only bit 0 of the upper address byte is kept. Bits 7..1 of that byte have no effect on the address loaded.
- R10: Data bytes that follow the two address bytes in a write-mode transfer are acknowledged but do not change the stored contents.
- R11: After reset SDA is released and the address counter is 0, so the first current-address read returns the byte at address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples the bus lines |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level (wired value) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| pl_we | input | 1 | Preload write strobe for the storage array |
| pl_addr | input | 9 | Preload address |
| pl_data | input | 8 | Preload data |

## Verification
A byte-level model in the bench holds its own copy of the storage array and its own address pointer, and every received byte and acknowledge bit is compared with it. Random-address reads at a low address tell apart a correct load of the two address bytes from a counter that is not loaded or is loaded from the wrong byte. Reads that cross 0x1FF show whether the counter wraps. Current-address reads after stop conditions show whether the counter keeps its value, and upper bytes with junk in bits 7..1 show whether those bits are dropped. A foreign address, a write-mode data byte, and clocks sent after a NACK each check that the target stays off the line, or leaves the stored byte as it was, in the cases where it should do nothing.

// File: rtl/srt_pkg.sv
package srt_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HDR,
    ST_HDR_ACK,
    ST_AHI,
    ST_AHI_ACK,
    ST_ALO,
    ST_ALO_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_RBYTE,
    ST_RACK
  } tgt_st_e;

endpackage

// File: rtl/srt_rst_sync.sv
module srt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/srt_line_mon.sv
module srt_line_mon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [SYNC_STAGES-1:0] scl_sh_q, scl_sh_d;
  logic [SYNC_STAGES-1:0] sda_sh_q, sda_sh_d;
  logic                   scl_p_q, sda_p_q;

  always_comb begin
    scl_sh_d = {scl_sh_q[SYNC_STAGES-2:0], scl_in};
    sda_sh_d = {sda_sh_q[SYNC_STAGES-2:0], sda_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh_q <= '1;
      sda_sh_q <= '1;
      scl_p_q  <= 1'b1;
      sda_p_q  <= 1'b1;
    end else begin
      scl_sh_q <= scl_sh_d;
      sda_sh_q <= sda_sh_d;
      scl_p_q  <= scl_s;
      sda_p_q  <= sda_s;
    end
  end

  assign scl_s     = scl_sh_q[SYNC_STAGES-1];
  assign sda_s     = sda_sh_q[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_p_q;
  assign scl_fall  = ~scl_s & scl_p_q;
  assign start_det = scl_s & scl_p_q & sda_p_q & ~sda_s;
  assign stop_det  = scl_s & scl_p_q & ~sda_p_q & sda_s;

endmodule

// File: rtl/srt_addr_ctr.sv
module srt_addr_ctr #(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc,
  output logic [AW-1:0] ptr
);

  logic [AW-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (load)     ptr_d = load_val;
    else if (inc) ptr_d = ptr_q + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

  // R6: stepping from the top address lands on zero
  assert_wrap_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load && (ptr_q == {AW{1'b1}})) |=> (ptr_q == '0));

  // R8: with no load and no step the counter keeps its value
  assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !load) |=> $stable(ptr_q));

endmodule

// File: rtl/srt_store.sv
module srt_store #(
  parameter int DEPTH = 512,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/serial_rom_target.sv
module serial_rom_target #(
  parameter int         DEPTH       = 512,
  parameter int         DW          = 8,
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         SYNC_STAGES = 2,
  localparam int        AW          = $clog2(DEPTH),
  localparam int        HI_BITS     = AW - DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          sda_oe,
  input  logic          pl_we,
  input  logic [AW-1:0] pl_addr,
  input  logic [DW-1:0] pl_data
);

  import srt_pkg::*;

  localparam logic [2:0] LAST_BIT = 3'd7;

  logic rst_q;
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  tgt_st_e             st_q, st_d;
  logic [2:0]          bc_q, bc_d;
  logic                full_q, full_d;
  logic                rw_q, rw_d;
  logic [HI_BITS-1:0]  hi_q, hi_d;
  logic [DW-1:0]       rx_q, rx_d;
  logic [DW-1:0]       tx_q, tx_d;
  logic                oe_q, oe_d;
  logic                ack_q, ack_d;

  logic                ctr_load, ctr_inc;
  logic [AW-1:0]       ctr_val, ptr;
  logic [DW-1:0]       rd_data;
  logic                rx_state;

  srt_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q)
  );

  srt_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk       (clk),
    .rst_n     (rst_q),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  srt_addr_ctr #(.AW(AW)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_q),
    .load     (ctr_load),
    .load_val (ctr_val),
    .inc      (ctr_inc),
    .ptr      (ptr)
  );

  srt_store #(.DEPTH(DEPTH), .DW(DW)) u_mem (
    .clk     (clk),
    .wr_en   (pl_we),
    .wr_addr (pl_addr),
    .wr_data (pl_data),
    .rd_addr (ptr),
    .rd_data (rd_data)
  );

  assign rx_state = (st_q == ST_HDR) || (st_q == ST_AHI) ||
                    (st_q == ST_ALO) || (st_q == ST_WDAT);
  assign ctr_val  = {hi_q, rx_q};

  // next-state logic
  always_comb begin
    st_d     = st_q;
    bc_d     = bc_q;
    full_d   = full_q;
    rw_d     = rw_q;
    hi_d     = hi_q;
    rx_d     = rx_q;
    tx_d     = tx_q;
    oe_d     = oe_q;
    ack_d    = ack_q;
    ctr_load = 1'b0;
    ctr_inc  = 1'b0;

    if (start_det) begin
      st_d   = ST_HDR;
      bc_d   = '0;
      full_d = 1'b0;
      oe_d   = 1'b0;
    end else if (stop_det) begin
      st_d   = ST_IDLE;
      full_d = 1'b0;
      oe_d   = 1'b0;
    end else if (scl_rise) begin
      if (rx_state) begin
        rx_d = {rx_q[DW-2:0], sda_s};
        bc_d = bc_q + 3'd1;
        if (bc_q == LAST_BIT) full_d = 1'b1;
      end else if (st_q == ST_RBYTE) begin
        bc_d = bc_q + 3'd1;
        if (bc_q == LAST_BIT) full_d = 1'b1;
      end else if (st_q == ST_RACK) begin
        ack_d   = ~sda_s;
        ctr_inc = 1'b1;
      end
    end else if (scl_fall) begin
      unique case (st_q)
        ST_HDR: begin
          if (full_q) begin
            full_d = 1'b0;
            if (rx_q[7:1] == DEV_ADDR) begin
              oe_d = 1'b1;
              rw_d = rx_q[0];
              st_d = ST_HDR_ACK;
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        ST_HDR_ACK: begin
          bc_d = '0;
          if (rw_q) begin
            st_d = ST_RBYTE;
            tx_d = rd_data;
            oe_d = ~rd_data[DW-1];
          end else begin
            st_d = ST_AHI;
            oe_d = 1'b0;
          end
        end
        ST_AHI: begin
          if (full_q) begin
            full_d = 1'b0;
            hi_d   = rx_q[HI_BITS-1:0];
            oe_d   = 1'b1;
            st_d   = ST_AHI_ACK;
          end
        end
        ST_AHI_ACK: begin
          oe_d = 1'b0;
          bc_d = '0;
          st_d = ST_ALO;
        end
        ST_ALO: begin
          if (full_q) begin
            full_d   = 1'b0;
            ctr_load = 1'b1;
            oe_d     = 1'b1;
            st_d     = ST_ALO_ACK;
          end
        end
        ST_ALO_ACK, ST_WDAT_ACK: begin
          oe_d = 1'b0;
          bc_d = '0;
          st_d = ST_WDAT;
        end
        ST_WDAT: begin
          if (full_q) begin
            full_d = 1'b0;
            oe_d   = 1'b1;
            st_d   = ST_WDAT_ACK;
          end
        end
        ST_RBYTE: begin
          if (full_q) begin
            full_d = 1'b0;
            oe_d   = 1'b0;
            st_d   = ST_RACK;
          end else begin
            tx_d = {tx_q[DW-2:0], 1'b0};
            oe_d = ~tx_q[DW-2];
          end
        end
        ST_RACK: begin
          if (ack_q) begin
            st_d = ST_RBYTE;
            bc_d = '0;
            tx_d = rd_data;
            oe_d = ~rd_data[DW-1];
          end else begin
            st_d = ST_IDLE;
            oe_d = 1'b0;
          end
        end
        default: begin
          oe_d = 1'b0;
        end
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      st_q   <= ST_IDLE;
      bc_q   <= '0;
      full_q <= 1'b0;
      rw_q   <= 1'b0;
      hi_q   <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      oe_q   <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      bc_q   <= bc_d;
      full_q <= full_d;
      rw_q   <= rw_d;
      hi_q   <= hi_d;
      rx_q   <= rx_d;
      tx_q   <= tx_d;
      oe_q   <= oe_d;
      ack_q  <= ack_d;
    end
  end

  assign sda_oe = oe_q;

  // R4: the data pin moves only while SCL is low, bar start/stop release
  assert_sda_moves_scl_low_R4: assert property (@(posedge clk) disable iff (!rst_q)
    !$stable(oe_q) |-> (!scl_s || $past(start_det || stop_det)));

  // R2: an idle target never pulls the line
  assert_idle_released_R2: assert property (@(posedge clk) disable iff (!rst_q)
    (st_q == ST_IDLE) |-> !oe_q);

  // R7: a NACK on the ninth clock ends the stream with SDA released
  assert_nack_ends_R7: assert property (@(posedge clk) disable iff (!rst_q)
    (st_q == ST_RACK && scl_fall && !ack_q && !start_det && !stop_det)
      |=> (st_q == ST_IDLE && !oe_q));

  // R1: a foreign header never yields an acknowledge state
  assert_hdr_match_R1: assert property (@(posedge clk) disable iff (!rst_q)
    (st_q == ST_HDR && scl_fall && full_q && (rx_q[7:1] != DEV_ADDR) && !start_det && !stop_det)
      |=> (st_q == ST_IDLE));

endmodule

// File: tb/serial_rom_target_tb_top.sv
module serial_rom_target_tb_top;

  localparam int         Q     = 8;
  localparam logic [6:0] DEV   = 7'h50;
  localparam int         LIMIT = 150000;

  logic       clk;
  logic       rst_n;
  logic       scl;
  logic       m_low;
  logic       sda_bus;
  logic       sda_oe;
  logic       pl_we;
  logic [8:0] pl_addr;
  logic [7:0] pl_data;

  int vectors;
  int miscompares;
  int cyc;
  bit done;

  logic [7:0] exp_mem [512];
  int         exp_ptr;

  assign sda_bus = ~(m_low | sda_oe);

  serial_rom_target dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_in  (scl),
    .sda_in  (sda_bus),
    .sda_oe  (sda_oe),
    .pl_we   (pl_we),
    .pl_addr (pl_addr),
    .pl_data (pl_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc == LIMIT && !done) begin
      miscompares++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_start();
    m_low = 1'b0; tick(Q);
    scl   = 1'b1; tick(Q);
    m_low = 1'b1; tick(Q);
    scl   = 1'b0; tick(Q);
  endtask

  task automatic do_stop();
    m_low = 1'b1; tick(Q);
    scl   = 1'b1; tick(Q);
    m_low = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ak);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; tick(Q);
      scl = 1'b1;    tick(2*Q);
      scl = 1'b0;    tick(Q);
    end
    m_low = 1'b0; tick(Q);
    scl = 1'b1;   tick(Q);
    ak = sda_bus; tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic recv_byte(input logic nak, output logic [7:0] b);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      tick(2*Q);
      scl = 1'b1; tick(Q);
      b[i] = sda_bus; tick(Q);
      scl = 1'b0;
    end
    tick(Q);
    m_low = ~nak; tick(Q);
    scl = 1'b1;   tick(2*Q);
    scl = 1'b0;   tick(Q);
    m_low = 1'b0;
  endtask

  task automatic header(input string req, input logic rd);
    logic ak;
    send_byte({DEV, rd}, ak);
    check(req, ak, 0);
  endtask

  task automatic stream(input string req, input int n);
    logic [7:0] d;
    for (int k = 0; k < n; k++) begin
      recv_byte(k == n-1, d);
      check(req, d, exp_mem[exp_ptr]);
      exp_ptr = (exp_ptr + 1) % 512;
    end
  endtask

  task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo);
    logic ak;
    do_start();
    header("R1 write header ack", 1'b0);
    send_byte(hi, ak); check("R3 upper address ack", ak, 0);
    send_byte(lo, ak); check("R3 lower address ack", ak, 0);
    exp_ptr = {hi[0], lo};
  endtask

  initial begin
    logic       ak;
    logic [7:0] d;
    vectors = 0; miscompares = 0; cyc = 0; done = 0;
    rst_n = 1'b0; scl = 1'b1; m_low = 1'b0;
    pl_we = 1'b0; pl_addr = '0; pl_data = '0;
    exp_ptr = 0;
    tick(6);
    rst_n = 1'b1;
    tick(6);
    check("R11 reset sda released", sda_oe, 0);

    for (int a = 0; a < 512; a++) begin
      exp_mem[a] = 8'((a * 29 + 90) ^ (a >> 4));
      pl_we = 1'b1; pl_addr = 9'(a); pl_data = exp_mem[a];
      tick(1);
    end
    pl_we = 1'b0;
    tick(4);

    // R11: counter at zero after reset, current-address read
    do_start();
    header("R1 read header ack", 1'b1);
    stream("R11 first current read", 1);
    do_stop();

    // R2: foreign address, SDA stays released
    do_start();
    send_byte({7'h23, 1'b0}, ak); check("R2 foreign header nack", ak, 1);
    send_byte(8'h00, ak);         check("R2 foreign byte nack", ak, 1);
    do_stop();

    // R3 R4 R5: random-address read, sequential stream
    set_addr(8'h01, 8'h23);
    do_start();
    header("R1 read header after restart", 1'b1);
    stream("R3 R4 R5 random read stream", 4);
    do_stop();

    // R8: current read resumes after last byte sent
    do_start();
    header("R1 read header", 1'b1);
    stream("R8 current read resumes", 2);
    do_stop();

    // R6: stream across the top address
    set_addr(8'h01, 8'hFE);
    do_start();
    header("R1 read header", 1'b1);
    stream("R6 wrap past top", 4);
    do_stop();

    // R9: upper bits 7..1 ignored
    set_addr(8'hFE, 8'h05);
    do_start();
    header("R1 read header", 1'b1);
    stream("R9 upper bits ignored low", 1);
    do_stop();
    set_addr(8'h7B, 8'h10);
    do_start();
    header("R1 read header", 1'b1);
    stream("R9 upper bits ignored high", 1);
    do_stop();

    // R10: write data acked but not stored
    set_addr(8'h00, 8'h40);
    send_byte(~exp_mem[9'h040], ak); check("R10 write data ack", ak, 0);
    do_stop();
    set_addr(8'h00, 8'h40);
    do_start();
    header("R1 read header", 1'b1);
    stream("R10 stored byte unchanged", 1);
    do_stop();

    // R7: after a NACK the target drives nothing until a start
    set_addr(8'h00, 8'h80);
    do_start();
    header("R1 read header", 1'b1);
    stream("R7 last byte before nack", 1);
    recv_byte(1'b1, d);
    check("R7 no drive after nack", d, 8'hFF);
    do_stop();
    do_start();
    header("R1 read header", 1'b1);
    stream("R7 R8 counter after nack", 1);
    do_stop();
    tick(4);
    check("R7 released after stop", sda_oe, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule